// File: doc/BRIEF.md
# Two-Wire Fast Serial Byte Transmitter

This block is the sending end of a fast byte protocol that runs over two shared open-collector lines, one for data and one for clock. Each byte crosses in four timed steps, each of which carries two payload bits at once: one on the data line and one on the clock line. A handshake comes before the byte (the receiver releases data, the sender releases both lines) and another after it (the receiver pulls data low to acknowledge). All step timing is counted in microsecond ticks, measured from the moment both lines are released.

The sender always keeps one byte back. A byte offered at the input is parked in a one-entry buffer. It goes onto the wire only when the next byte arrives or when the end-of-stream strobe comes, so the last byte of a stream can carry the end marker. That marker travels as the level of the clock line in the slot after the payload. A start is also held back while a raster-derived phase value shows that a blocking window is close, so that a transfer never overlaps one.

The line outputs are active-low drive enables, where 1 leaves the line released and 0 pulls it low. The data input is the level read back from the shared data line.

Top module: `duoline_tx`

## Requirements
- R1: Out of reset, dataOeN is 1 and clockOeN is 0 (data released, clock driven low), and doneOut and errOut are 0.
- R2: A byte accepted while the hold buffer is empty is only stored. No start happens until a second byte or the end strobe arrives.
- R3: A byte accepted while the buffer is full sends the held byte with the end marker off and takes the new byte's place. eoiStrobe while the buffer is full sends the held byte with the end marker on and empties the buffer. eoiStrobe while the buffer is empty has no effect.
- R4: A start never happens while dataIn reads 0 (the receiver holds data low).
- R5: A start never happens while (rasterLow − scrollVal) mod 8 is 6 or 7. Any other phase value allows it.
- R6: The start is the first cycle with dataOeN = 1 and clockOeN = 1 after the rest state. Tick count 0 is taken at that point, and each later usTick adds one.
- R7: The pairs {dataOeN, clockOeN} hold these values across these tick counts: ticks 13–20 carry {bit5, bit4}, ticks 26–33 carry {bit7, bit6}, ticks 37–44 carry {bit1, bit3}, and ticks 50–57 carry {bit0, bit2}. Bit 7 is the most significant bit of byteIn.
- R8: Across ticks 63–70, dataOeN is 1. clockOeN is 1 when the byte carries the end marker and 0 when it does not.
- R9: From tick 75 clockOeN is 0. At tick 80 the sender reads dataIn: 0 gives a one-cycle doneOut pulse and 1 gives a one-cycle errOut pulse. The two are never high together.
- R10: byteValid and eoiStrobe are ignored from the cycle a byte is handed to the wire until its doneOut or errOut pulse. A byte offered in that time is never sent, and the buffered byte is left unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteValid | input | 1 | One-cycle strobe offering byteIn |
| byteIn | input | 8 | Byte to send |
| eoiStrobe | input | 1 | End of stream: send the held byte with the end marker |
| usTick | input | 1 | One-cycle pulse each microsecond |
| rasterLow | input | 3 | Low three bits of the raster line count |
| scrollVal | input | 3 | Vertical scroll value |
| dataIn | input | 1 | Level read back from the data line (1 = released) |
| dataOeN | output | 1 | Data line drive enable, active low |
| clockOeN | output | 1 | Clock line drive enable, active low |
| doneOut | output | 1 | One-cycle pulse: byte acknowledged |
| errOut | output | 1 | One-cycle pulse: no acknowledge seen |

## Verification
The hardest situations to reach are the two gates that delay a start: a receiver still holding data low, and a phase value that wraps through the modulo, such as a raster value below the scroll value. The bench models the receiver's pull on the data line as a wired-AND. It holds that pull, or parks the raster and scroll inputs on phases 6 and 7, while a byte is pending, watches that the lines stay at rest, and then opens the gate. Random bytes run under random allowed phases and random release delays, and each two-bit slot is checked at every tick of its sampling window.

// File: rtl/duoline_pkg.sv
package duoline_pkg;

  localparam int PHASE_W   = 3;
  localparam int BLOCK_MIN = 6;
  localparam int TIMER_W   = 7;

  // tick counts (after start) at which the line pair changes
  localparam int T_PAIR0  = 6;
  localparam int T_PAIR1  = 23;
  localparam int T_PAIR2  = 35;
  localparam int T_PAIR3  = 47;
  localparam int T_MARK   = 60;
  localparam int T_CLKDRV = 75;
  localparam int T_CHECK  = 80;

  localparam int NUM_PAIRS = 4;
  // payload bit carried on each line in each step; the order is the protocol
  localparam int PAIR_DATA_BIT [NUM_PAIRS] = '{5, 7, 1, 0};
  localparam int PAIR_CLK_BIT  [NUM_PAIRS] = '{4, 6, 3, 2};

  typedef enum logic [2:0] {
    LN_REST, LN_START, LN_PAIR0, LN_PAIR1, LN_PAIR2, LN_PAIR3, LN_MARK
  } lineCode_t;

  typedef enum logic [1:0] {S_IDLE, S_WAIT_DATA, S_WAIT_WIN, S_RUN} txState_t;

  typedef struct packed {
    logic      holdLoad;
    logic      holdClear;
    logic      txLatch;
    logic      txMark;
    logic      lineWe;
    lineCode_t line;
  } dpStrobe_t;

endpackage

// File: rtl/duoline_dp.sv
module duoline_dp
  import duoline_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  dpStrobe_t  st,
  input  logic [7:0] byteIn,
  output logic       holdValid,
  output logic       dataOeN,
  output logic       clockOeN
);

  logic [7:0] holdByte;
  logic [7:0] txByte;
  logic       txMark;
  lineCode_t  line;
  logic [NUM_PAIRS-1:0] pairData;
  logic [NUM_PAIRS-1:0] pairClk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdByte  <= '0;
      holdValid <= 1'b0;
      txByte    <= '0;
      txMark    <= 1'b0;
      line      <= LN_REST;
    end else begin
      if (st.holdLoad) begin
        holdByte  <= byteIn;
        holdValid <= 1'b1;
      end else if (st.holdClear) begin
        holdValid <= 1'b0;
      end
      if (st.txLatch) begin
        txByte <= holdByte;
        txMark <= st.txMark;
      end
      if (st.lineWe) line <= st.line;
    end
  end

  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
    assign pairData[g] = txByte[PAIR_DATA_BIT[g]];
    assign pairClk[g]  = txByte[PAIR_CLK_BIT[g]];
  end

  always_comb begin
    case (line)
      LN_START: {dataOeN, clockOeN} = 2'b11;
      LN_PAIR0: {dataOeN, clockOeN} = {pairData[0], pairClk[0]};
      LN_PAIR1: {dataOeN, clockOeN} = {pairData[1], pairClk[1]};
      LN_PAIR2: {dataOeN, clockOeN} = {pairData[2], pairClk[2]};
      LN_PAIR3: {dataOeN, clockOeN} = {pairData[3], pairClk[3]};
      LN_MARK:  {dataOeN, clockOeN} = {1'b1, txMark};
      default:  {dataOeN, clockOeN} = 2'b10;
    endcase
  end

endmodule

// File: rtl/duoline_ctrl.sv
module duoline_ctrl
  import duoline_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               byteValid,
  input  logic               eoiStrobe,
  input  logic               holdValid,
  input  logic               usTick,
  input  logic               dataIn,
  input  logic [PHASE_W-1:0] rasterLow,
  input  logic [PHASE_W-1:0] scrollVal,
  output dpStrobe_t          st,
  output logic               startPulse,
  output logic               doneOut,
  output logic               errOut
);

  txState_t           state, nxtState;
  logic [TIMER_W-1:0] tCnt, nxtT;
  logic [PHASE_W-1:0] phase;
  logic               doneNxt, errNxt;

  assign phase = rasterLow - scrollVal;

  always_comb begin
    st         = '0;
    nxtState   = state;
    nxtT       = tCnt;
    startPulse = 1'b0;
    doneNxt    = 1'b0;
    errNxt     = 1'b0;
    case (state)
      S_IDLE: begin
        if (byteValid) begin
          st.holdLoad = 1'b1;
          if (holdValid) begin
            st.txLatch = 1'b1;
            nxtState   = S_WAIT_DATA;
          end
        end else if (eoiStrobe && holdValid) begin
          st.txLatch   = 1'b1;
          st.txMark    = 1'b1;
          st.holdClear = 1'b1;
          nxtState     = S_WAIT_DATA;
        end
      end
      S_WAIT_DATA: if (dataIn) nxtState = S_WAIT_WIN;
      S_WAIT_WIN: begin
        if (!dataIn) begin
          nxtState = S_WAIT_DATA;
        end else if (phase < PHASE_W'(BLOCK_MIN)) begin
          startPulse = 1'b1;
          st.lineWe  = 1'b1;
          st.line    = LN_START;
          nxtT       = '0;
          nxtState   = S_RUN;
        end
      end
      default: begin
        if (usTick) begin
          nxtT = tCnt + 1'b1;
          case (nxtT)
            TIMER_W'(T_PAIR0):  begin st.lineWe = 1'b1; st.line = LN_PAIR0; end
            TIMER_W'(T_PAIR1):  begin st.lineWe = 1'b1; st.line = LN_PAIR1; end
            TIMER_W'(T_PAIR2):  begin st.lineWe = 1'b1; st.line = LN_PAIR2; end
            TIMER_W'(T_PAIR3):  begin st.lineWe = 1'b1; st.line = LN_PAIR3; end
            TIMER_W'(T_MARK):   begin st.lineWe = 1'b1; st.line = LN_MARK;  end
            TIMER_W'(T_CLKDRV): begin st.lineWe = 1'b1; st.line = LN_REST;  end
            TIMER_W'(T_CHECK): begin
              nxtState = S_IDLE;
              doneNxt  = !dataIn;
              errNxt   = dataIn;
            end
            default: ;
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      tCnt    <= '0;
      doneOut <= 1'b0;
      errOut  <= 1'b0;
    end else begin
      state   <= nxtState;
      tCnt    <= nxtT;
      doneOut <= doneNxt;
      errOut  <= errNxt;
    end
  end

endmodule

// File: rtl/duoline_tx.sv
module duoline_tx
  import duoline_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       byteValid,
  input  logic [7:0] byteIn,
  input  logic       eoiStrobe,
  input  logic       usTick,
  input  logic [2:0] rasterLow,
  input  logic [2:0] scrollVal,
  input  logic       dataIn,
  output logic       dataOeN,
  output logic       clockOeN,
  output logic       doneOut,
  output logic       errOut
);

  dpStrobe_t st;
  logic      holdValid;
  logic      startPulse;

  duoline_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .eoiStrobe(eoiStrobe),
    .holdValid(holdValid), .usTick(usTick), .dataIn(dataIn),
    .rasterLow(rasterLow), .scrollVal(scrollVal), .st(st),
    .startPulse(startPulse), .doneOut(doneOut), .errOut(errOut)
  );

  duoline_dp u_dp (
    .clk(clk), .rstN(rstN), .st(st), .byteIn(byteIn),
    .holdValid(holdValid), .dataOeN(dataOeN), .clockOeN(clockOeN)
  );

endmodule

// File: rtl/duoline_chk.sv
module duoline_chk (
  input logic       clk,
  input logic       rstN,
  input logic       dataIn,
  input logic [2:0] rasterLow,
  input logic [2:0] scrollVal,
  input logic       startPulse,
  input logic       dataOeN,
  input logic       clockOeN,
  input logic       doneOut,
  input logic       errOut
);

  logic [2:0] chkPhase;
  assign chkPhase = rasterLow - scrollVal;

  AST_START_DATA_FREE: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |-> dataIn);                                        // R4
  AST_START_OUTSIDE_BLOCK: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |-> (chkPhase != 3'd6 && chkPhase != 3'd7));        // R5
  AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> (dataOeN && clockOeN));                         // R6
  AST_DONE_ACKED: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> $past(!dataIn));                                   // R9
  AST_ERR_UNACKED: assert property (@(posedge clk) disable iff (!rstN)
    errOut |-> $past(dataIn));                                     // R9
  AST_END_CLOCK_DRIVEN: assert property (@(posedge clk) disable iff (!rstN)
    (doneOut || errOut) |-> !clockOeN);                            // R9
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);                                         // R9
  AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rstN)
    !(doneOut && errOut));                                         // R9

endmodule

bind duoline_tx duoline_chk u_chk (
  .clk(clk), .rstN(rstN), .dataIn(dataIn), .rasterLow(rasterLow),
  .scrollVal(scrollVal), .startPulse(startPulse), .dataOeN(dataOeN),
  .clockOeN(clockOeN), .doneOut(doneOut), .errOut(errOut)
);

// File: tb/sim_duoline_tx.sv
`timescale 1ns/1ps
module sim_duoline_tx;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       byteValid = 1'b0;
  logic [7:0] byteIn = '0;
  logic       eoiStrobe = 1'b0;
  logic       usTick = 1'b0;
  logic [2:0] rasterLow = '0;
  logic [2:0] scrollVal = '0;
  logic       rxPull = 1'b0;
  logic       dataIn;
  logic       dataOeN, clockOeN, doneOut, errOut;
  int         nChecks = 0;
  int         nFail = 0;
  int         divCnt = 0;
  bit         finished = 1'b0;

  always #2.5 clk = ~clk;

  assign dataIn = dataOeN & ~rxPull;

  always @(negedge clk) begin
    divCnt = (divCnt + 1) % 4;
    usTick = (divCnt == 0);
  end

  duoline_tx u0 (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteIn(byteIn),
    .eoiStrobe(eoiStrobe), .usTick(usTick), .rasterLow(rasterLow),
    .scrollVal(scrollVal), .dataIn(dataIn), .dataOeN(dataOeN),
    .clockOeN(clockOeN), .doneOut(doneOut), .errOut(errOut)
  );

  function automatic logic [1:0] expPair(input logic [7:0] b, input int p);
    case (p)
      0:       return {b[5], b[4]};
      1:       return {b[7], b[6]};
      2:       return {b[1], b[3]};
      default: return {b[0], b[2]};
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk); byteValid = 1'b1; byteIn = b;
    @(negedge clk); byteValid = 1'b0;
  endtask

  task automatic sendEoi();
    @(negedge clk); eoiStrobe = 1'b1;
    @(negedge clk); eoiStrobe = 1'b0;
  endtask

  task automatic noStart(input int n, input string req);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!(dataOeN && !clockOeN)) bad++;
    end
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic xfer(input logic [7:0] b, input bit mark, input bit ack,
                      input int relDelay);
    int w = 0;
    int k = 0;
    int badPair [4] = '{0, 0, 0, 0};
    int badMark = 0;
    int badClk = 0;
    while (!(dataOeN && clockOeN) && w < 4000) begin
      @(negedge clk); w++;
    end
    chk(w < 4000, "R6 start seen", w, 0);
    while (k < 80) begin
      @(posedge clk);
      if (usTick) k++;
      @(negedge clk);
      for (int p = 0; p < 4; p++) begin
        int lo = (p == 0) ? 13 : (p == 1) ? 26 : (p == 2) ? 37 : 50;
        if (k >= lo && k <= lo + 7 && {dataOeN, clockOeN} != expPair(b, p))
          badPair[p]++;
      end
      if (k >= 63 && k <= 70 && {dataOeN, clockOeN} != {1'b1, mark}) badMark++;
      if (k >= 75 && clockOeN) badClk++;
      if (k >= 70 && ack) rxPull = 1'b1;
      if (k < 80 && (doneOut || errOut)) badClk++;
    end
    for (int p = 0; p < 4; p++)
      chk(badPair[p] == 0, "R7 pair window", badPair[p], 0);
    chk(badMark == 0, "R8 end marker slot", badMark, 0);
    chk(badClk == 0, "R9 clock driven and no early flag", badClk, 0);
    chk({doneOut, errOut} == {ack, !ack}, "R9 done/err at tick 80",
        {doneOut, errOut}, {ack, !ack});
    @(negedge clk);
    chk({doneOut, errOut} == 2'b00, "R9 single-cycle flag", {doneOut, errOut}, 0);
    repeat (relDelay) @(negedge clk);
    rxPull = 1'b0;
  endtask

  initial begin
    logic [7:0] prev;
    logic [7:0] cur;
    void'($urandom(32'd1543));
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk({dataOeN, clockOeN, doneOut, errOut} == 4'b1000, "R1 reset state",
        {dataOeN, clockOeN, doneOut, errOut}, 4'b1000);

    // R2: lone byte is held
    sendByte(8'hA5);
    noStart(150, "R2 held byte not sent");
    // R3: next byte pushes the held one without marker, end strobe with marker
    sendByte(8'h3C);
    xfer(8'hA5, 1'b0, 1'b1, 10);
    sendEoi();
    xfer(8'h3C, 1'b1, 1'b1, 3);
    sendEoi();
    noStart(150, "R3 end strobe on empty buffer");

    // R4: receiver holds data low
    rxPull = 1'b1;
    sendByte(8'h11);
    sendByte(8'hE7);
    noStart(300, "R4 data held low");
    rxPull = 1'b0;
    xfer(8'h11, 1'b0, 1'b1, 0);

    // R5: blocking phases 6 and 7, including wrap below the scroll value
    rasterLow = 3'd1; scrollVal = 3'd3;
    sendByte(8'h5A);
    noStart(150, "R5 phase 6 blocks");
    rasterLow = 3'd2;
    noStart(150, "R5 phase 7 blocks");
    rasterLow = 3'd0;
    xfer(8'hE7, 1'b0, 1'b1, 5);

    // R10: input ignored during a transfer
    sendByte(8'hC3);
    fork
      xfer(8'h5A, 1'b0, 1'b1, 2);
      begin
        repeat (120) @(negedge clk);
        sendByte(8'h99);
        sendEoi();
      end
    join
    noStart(60, "R10 strobe during transfer ignored");
    sendEoi();
    xfer(8'hC3, 1'b1, 1'b1, 4);

    // R9: no acknowledge gives error
    sendByte(8'h0F);
    sendByte(8'hF0);
    xfer(8'h0F, 1'b0, 1'b0, 0);
    sendEoi();
    xfer(8'hF0, 1'b1, 1'b1, 1);

    // random stream under allowed phases
    prev = 8'($urandom);
    sendByte(prev);
    for (int i = 0; i < 20; i++) begin
      logic [2:0] ph;
      cur = 8'($urandom);
      ph = 3'($urandom % 6);
      scrollVal = 3'($urandom);
      rasterLow = scrollVal + ph;
      sendByte(cur);
      xfer(prev, 1'b0, 1'b1, int'($urandom % 30));
      prev = cur;
    end
    sendEoi();
    xfer(prev, 1'b1, 1'b1, 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

endmodule